// File: doc/BRIEF.md
# Scan-Mode Line Output Port

This block decides when the image sensor begins reading out a line and hands each finished binary line to the host. A host request input, `vreq_n` (active low), is read three ways. In free scan it is ignored and readouts follow a programmed interval. In cycle scan a readout starts at an interval boundary only while the request is held low. In trigger scan each falling edge of the request starts one readout immediately. The block drives the sensor start pulse, `start_n`, and raises a one-cycle `overrun` flag when a readout begins before the previous line has been delivered.

A binary line buffer raises `lb_ready` when a processed line is waiting. The port then streams that line out through one of two outputs. The serial port frames the line with `vsen_n` and shifts pixels on `vsda` against a half-rate clock `vsck`. The parallel port requests transfers on `dreq_n` and hands over one byte per cycle in which `dack_n` is low. In the buffer each byte holds eight pixels, first pixel in bit 7, with 1 meaning black. The buffer is read combinationally at `lb_rd_addr`. `lb_done` pulses once a line has fully left the block, and the buffer releases that line on this pulse.

Top module: `scan_line_port`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `start_n`=1, `overrun`=0, `vsen_n`=1, `vsck`=0, `vsda`=1, `dreq_n`=1, `pd_oe`=0 and `lb_done`=0.
- R2: Free scan (`cfg_mode`=0, and 3 behaves the same) fires a start every `cfg_interval` cycles whatever `vreq_n` does. Each start holds `start_n` low for START_W cycles. `cfg_interval` must exceed START_W.
- R3: Cycle scan (`cfg_mode`=1) fires a start at an interval boundary only if the registered `vreq_n` is low there. With the request high, no start occurs.
- R4: Trigger scan (`cfg_mode`=2) drives `start_n` low at the second rising clock edge after `vreq_n` falls. Exactly one pulse is produced per falling edge, and no start occurs without a falling edge.
- R5: In serial mode (`cfg_par`=0), `vsen_n` stays low for exactly 2×LINE_PIX cycles per line. While framed, `vsck` alternates low/high each cycle, starting low. `vsck` is never high outside the frame. `vsda` changes inside the frame only as `vsck` falls.
- R6: Serial data is sent pixel by pixel, bit 7 of each byte first and byte 0 first. `vsda` is low for a black pixel (1) and high for white (0). The host samples `vsda` while `vsck` is high.
- R7: In parallel mode (`cfg_par`=1), `dreq_n` goes low once a line is ready. `pd_oe` is high exactly in the cycles where `dack_n` is low and a transfer is pending. `pd_dat` shows buffer byte 0, then the next byte after each cycle with `dack_n` low, and the bits go out unchanged (bit 7 = first pixel, 1 = black).
- R8: `dreq_n` returns high at the same edge that consumes the last byte, and `lb_done` pulses high for that one cycle. `dreq_n` then stays high, even with `dack_n` held low, until the next line is ready. The serial port ignores `dack_n`.
- R9: `overrun` pulses for one cycle, in the cycle when `start_n` falls, if the previous line started has not been delivered. A line whose `lb_done` is high in the cycle the start fires counts as delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Scan mode: 0 free, 1 cycle, 2 trigger, 3 as free |
| cfg_par | input | 1 | 1 selects the parallel port, 0 the serial port |
| cfg_interval | input | IVL_W | Line interval in clock cycles |
| vreq_n | input | 1 | Host request, active low |
| start_n | output | 1 | Sensor start pulse, active low |
| overrun | output | 1 | One-cycle flag: readout began before delivery |
| lb_ready | input | 1 | Line buffer holds a processed line |
| lb_rd_addr | output | BW | Byte address into the line buffer |
| lb_rd_data | input | 8 | Byte at `lb_rd_addr`, same cycle |
| lb_done | output | 1 | One-cycle pulse: line fully sent |
| vsen_n | output | 1 | Serial frame enable, active low |
| vsck | output | 1 | Serial clock, half the system rate |
| vsda | output | 1 | Serial pixel, low = black |
| dreq_n | output | 1 | Parallel transfer request, active low |
| dack_n | input | 1 | Parallel acknowledge, one byte per low cycle |
| pd_oe | output | 1 | Output enable for the external 8-bit bus driver |
| pd_dat | output | 8 | Parallel byte, bit 7 first pixel, 1 = black |

## Verification
Two events can fall in the same clock cycle: the last parallel byte being acknowledged and the next free-scan start coming due. The bench runs free scan with a 40-cycle interval, raises a line right after one start, and holds `dack_n` low so that the fourth acknowledge lands on the cycle before the next start. The edge that fires the start then also sees `lb_done`. That start must report no overrun, while the start one interval later, with nothing delivered, must report one.

// File: rtl/scan_line_pkg.sv
package scan_line_pkg;
  typedef enum logic [1:0] {
    SCAN_FREE  = 2'd0,
    SCAN_CYCLE = 2'd1,
    SCAN_TRIG  = 2'd2,
    SCAN_ALT   = 2'd3
  } scan_mode_e;
endpackage

// File: rtl/scan_line_seq.sv
module scan_line_seq
  import scan_line_pkg::*;
#(
  parameter int IVL_W   = 16,
  parameter int START_W = 4,
  localparam int PW     = $clog2(START_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [IVL_W-1:0] interval,
  input  logic             vreq_n,
  input  logic             line_done,
  output logic             start_n,
  output logic             overrun
);
  scan_mode_e     m;
  logic [IVL_W-1:0] cnt;
  logic [IVL_W:0]   cnt_nx;
  logic           tick, timed, due, fire, pulse_on, busy;
  logic           vq1, vq2;
  logic [PW-1:0]  pcnt;

  assign m      = scan_mode_e'(mode);
  assign timed  = (m != SCAN_TRIG);
  assign cnt_nx = {1'b0, cnt} + {{IVL_W{1'b0}}, 1'b1};
  assign tick   = timed && (cnt_nx >= {1'b0, interval});

  // interval timer, idle in trigger scan
  always_ff @(posedge clk) begin
    if (rst || !timed) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt_nx[IVL_W-1:0];
  end

  // request sampling, edge detect for trigger scan
  always_ff @(posedge clk) begin
    if (rst) begin
      vq1 <= 1'b1;
      vq2 <= 1'b1;
    end else begin
      vq1 <= vreq_n;
      vq2 <= vq1;
    end
  end

  always_comb begin
    case (m)
      SCAN_CYCLE: due = tick && !vq1;
      SCAN_TRIG:  due = vq2 && !vq1;
      default:    due = tick;
    endcase
  end

  assign pulse_on = (pcnt != '0);
  assign fire     = due && !pulse_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      start_n <= 1'b1;
      overrun <= 1'b0;
      busy    <= 1'b0;
    end else begin
      if (fire)          pcnt <= PW'(START_W);
      else if (pulse_on) pcnt <= pcnt - PW'(1);
      start_n <= !(fire || (pcnt > PW'(1)));
      overrun <= fire && busy && !line_done;
      if (fire)           busy <= 1'b1;
      else if (line_done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/scan_line_ser.sv
module scan_line_ser #(
  parameter int BYTES = 4,
  parameter int BW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [7:0]    byte_in,
  output logic [BW-1:0] addr,
  output logic          busy,
  output logic          done,
  output logic          vsen_n,
  output logic          vsck,
  output logic          vsda
);
  logic [7:0]    sh;
  logic [2:0]    bitc;
  logic [BW-1:0] bcnt;
  logic          last;

  assign last = (bcnt == BW'(BYTES - 1));
  assign addr = busy ? bcnt + BW'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; vsen_n <= 1'b1; vsck <= 1'b0;
      vsda <= 1'b1; sh <= '0; bitc <= '0; bcnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1; vsen_n <= 1'b0; vsck <= 1'b0;
          sh <= byte_in; vsda <= !byte_in[7]; bitc <= '0; bcnt <= '0;
        end
      end else if (!vsck) begin
        vsck <= 1'b1;
      end else begin
        vsck <= 1'b0;
        if (bitc == 3'd7) begin
          if (last) begin
            busy <= 1'b0; done <= 1'b1; vsen_n <= 1'b1; vsda <= 1'b1;
            bcnt <= '0;
          end else begin
            sh <= byte_in; vsda <= !byte_in[7]; bitc <= '0;
            bcnt <= bcnt + BW'(1);
          end
        end else begin
          sh   <= {sh[6:0], 1'b0};
          vsda <= !sh[6];
          bitc <= bitc + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/scan_line_par.sv
module scan_line_par #(
  parameter int BYTES = 4,
  parameter int BW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          dack_n,
  input  logic [7:0]    byte_in,
  output logic [BW-1:0] addr,
  output logic          busy,
  output logic          done,
  output logic          dreq_n,
  output logic          pd_oe,
  output logic [7:0]    pd_dat
);
  logic [BW-1:0] bcnt;
  logic          last;

  assign last  = (bcnt == BW'(BYTES - 1));
  assign addr  = busy ? bcnt + BW'(1) : '0;
  assign pd_oe = busy && !dack_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; dreq_n <= 1'b1; pd_dat <= '0; bcnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy <= 1'b1; dreq_n <= 1'b0; pd_dat <= byte_in; bcnt <= '0;
        end
      end else if (!dack_n) begin
        if (last) begin
          busy <= 1'b0; dreq_n <= 1'b1; done <= 1'b1; bcnt <= '0;
        end else begin
          pd_dat <= byte_in;
          bcnt   <= bcnt + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/scan_line_port.sv
module scan_line_port
  import scan_line_pkg::*;
#(
  parameter int LINE_PIX = 32,
  parameter int IVL_W    = 16,
  parameter int START_W  = 4,
  localparam int BYTES   = LINE_PIX / 8,
  localparam int BW      = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_par,
  input  logic [IVL_W-1:0] cfg_interval,
  input  logic             vreq_n,
  output logic             start_n,
  output logic             overrun,
  input  logic             lb_ready,
  output logic [BW-1:0]    lb_rd_addr,
  input  logic [7:0]       lb_rd_data,
  output logic             lb_done,
  output logic             vsen_n,
  output logic             vsck,
  output logic             vsda,
  output logic             dreq_n,
  input  logic             dack_n,
  output logic             pd_oe,
  output logic [7:0]       pd_dat
);
  logic          s_busy, s_done, p_busy, p_done, go;
  logic [BW-1:0] s_addr, p_addr;

  assign lb_done    = s_done || p_done;
  assign go         = lb_ready && !lb_done && !s_busy && !p_busy;
  assign lb_rd_addr = p_busy ? p_addr : s_addr;

  scan_line_seq #(.IVL_W(IVL_W), .START_W(START_W)) u_seq (
    .clk(clk), .rst(rst), .mode(cfg_mode), .interval(cfg_interval),
    .vreq_n(vreq_n), .line_done(lb_done), .start_n(start_n), .overrun(overrun)
  );

  scan_line_ser #(.BYTES(BYTES), .BW(BW)) u_ser (
    .clk(clk), .rst(rst), .go(go && !cfg_par), .byte_in(lb_rd_data),
    .addr(s_addr), .busy(s_busy), .done(s_done),
    .vsen_n(vsen_n), .vsck(vsck), .vsda(vsda)
  );

  scan_line_par #(.BYTES(BYTES), .BW(BW)) u_par (
    .clk(clk), .rst(rst), .go(go && cfg_par), .dack_n(dack_n),
    .byte_in(lb_rd_data), .addr(p_addr), .busy(p_busy), .done(p_done),
    .dreq_n(dreq_n), .pd_oe(pd_oe), .pd_dat(pd_dat)
  );
endmodule

// File: rtl/scan_line_port_chk.sv
module scan_line_port_chk #(
  parameter int START_W = 4
) (
  input logic clk,
  input logic rst,
  input logic start_n,
  input logic overrun,
  input logic lb_done,
  input logic vsen_n,
  input logic vsck,
  input logic vsda,
  input logic dreq_n,
  input logic dack_n,
  input logic pd_oe
);
  localparam int LW = $clog2(START_W + 2) + 1;
  logic [LW-1:0] lowc;

  always_ff @(posedge clk) begin
    if (rst)                  lowc <= '0;
    else if (start_n)         lowc <= '0;
    else if (lowc != '1)      lowc <= lowc + LW'(1);
  end

  // R2
  start_width_chk: assert property (@(posedge clk) disable iff (rst)
    !start_n |-> (lowc < LW'(START_W)));
  // R5
  vsck_framed_chk: assert property (@(posedge clk) disable iff (rst)
    vsck |-> !vsen_n);
  // R5
  vsda_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!vsen_n && !$past(vsen_n) && (vsda != $past(vsda))) |-> (!vsck && $past(vsck)));
  // R7
  bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
    pd_oe |-> (!dack_n && !dreq_n));
  // R7
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!vsen_n && !dreq_n));
  // R8
  dreq_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dreq_n) |-> lb_done);
  // R9
  overrun_start_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $fell(start_n));
endmodule

bind scan_line_port scan_line_port_chk #(.START_W(START_W)) u_chk (
  .clk(clk), .rst(rst), .start_n(start_n), .overrun(overrun), .lb_done(lb_done),
  .vsen_n(vsen_n), .vsck(vsck), .vsda(vsda), .dreq_n(dreq_n), .dack_n(dack_n),
  .pd_oe(pd_oe)
);

// File: tb/scan_line_port_bench.sv
module scan_line_port_bench;
  localparam int LINE_PIX = 32;
  localparam int START_W  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_par = 1'b0;
  logic [15:0] cfg_interval = 16'd20;
  logic        vreq_n = 1'b1;
  logic        lb_ready = 1'b0;
  logic        dack_n = 1'b1;
  logic        start_n, overrun, lb_done, vsen_n, vsck, vsda, dreq_n, pd_oe;
  logic [1:0]  lb_rd_addr;
  logic [7:0]  lb_rd_data, pd_dat;
  logic [7:0]  mem [0:3];

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  assign lb_rd_data = mem[lb_rd_addr];

  scan_line_port #(.LINE_PIX(LINE_PIX), .IVL_W(16), .START_W(START_W)) u_scan_line_port (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_par(cfg_par),
    .cfg_interval(cfg_interval), .vreq_n(vreq_n), .start_n(start_n),
    .overrun(overrun), .lb_ready(lb_ready), .lb_rd_addr(lb_rd_addr),
    .lb_rd_data(lb_rd_data), .lb_done(lb_done), .vsen_n(vsen_n), .vsck(vsck),
    .vsda(vsda), .dreq_n(dreq_n), .dack_n(dack_n), .pd_oe(pd_oe), .pd_dat(pd_dat)
  );

  // buffer model: release the line on lb_done
  initial forever begin
    @(negedge clk);
    if (lb_done) lb_ready = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] mode, input logic par, input logic [15:0] ivl);
    @(negedge clk);
    rst = 1'b1; cfg_mode = mode; cfg_par = par; cfg_interval = ivl;
    vreq_n = 1'b1; dack_n = 1'b1; lb_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // returns the number of negedges until start_n is seen falling
  task automatic wait_fall(output int n);
    logic prev;
    prev = start_n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (start_n == 1'b0 && prev == 1'b1) break;
      prev = start_n;
    end while (n < 2000);
  endtask

  task automatic count_falls(input int cycles, output int falls);
    logic prev;
    prev = start_n;
    falls = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!start_n && prev) falls++;
      prev = start_n;
    end
  endtask

  task automatic t_reset();
    do_reset(2'd0, 1'b0, 16'd20);
    @(negedge clk);
    // R1 first cycle after reset
    chk("R1 start_n", start_n, 1'b1);
    chk("R1 overrun", overrun, 1'b0);
    chk("R1 vsen_n", vsen_n, 1'b1);
    chk("R1 vsck", vsck, 1'b0);
    chk("R1 vsda", vsda, 1'b1);
    chk("R1 dreq_n", dreq_n, 1'b1);
    chk("R1 pd_oe", pd_oe, 1'b0);
    chk("R1 lb_done", lb_done, 1'b0);
  endtask

  task automatic t_free();
    int n, w;
    do_reset(2'd0, 1'b0, 16'd20);
    wait_fall(n);
    w = 0;
    while (!start_n && w < 50) begin @(negedge clk); w++; end
    chk("R2 pulse width", w, START_W);
    vreq_n = 1'b0;
    wait_fall(n);
    chk("R2 period, vreq low", n + w, 20);
    vreq_n = 1'b1;
    wait_fall(n);
    chk("R2 period, vreq high", n, 20);
  endtask

  task automatic t_cycle();
    int n, f;
    do_reset(2'd1, 1'b0, 16'd16);
    count_falls(80, f);
    chk("R3 no start while vreq high", f, 0);
    vreq_n = 1'b0;
    wait_fall(n);
    wait_fall(n);
    chk("R3 period while vreq low", n, 16);
    vreq_n = 1'b1;
    count_falls(64, f);
    chk("R3 starts stop after vreq high", f, 0);
  endtask

  task automatic t_trig();
    int f;
    do_reset(2'd2, 1'b0, 16'd10);
    count_falls(40, f);
    chk("R4 no start without edge", f, 0);
    vreq_n = 1'b0;
    @(negedge clk);
    chk("R4 after first edge", start_n, 1'b1);
    @(negedge clk);
    chk("R4 low at second edge", start_n, 1'b0);
    count_falls(40, f);
    chk("R4 single pulse while held", f, 0);
    vreq_n = 1'b1;
    repeat (3) @(negedge clk);
    vreq_n = 1'b0;
    count_falls(6, f);
    chk("R4 second falling edge", f, 1);
    vreq_n = 1'b1;
  endtask

  task automatic t_serial();
    logic [31:0] got;
    int bad_clk, bad_en;
    do_reset(2'd2, 1'b0, 16'd20);
    mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h0F; mem[3] = 8'h81;
    dack_n = 1'b0;
    @(negedge clk);
    lb_ready = 1'b1;
    got = '0; bad_clk = 0; bad_en = 0;
    for (int k = 0; k < 2 * LINE_PIX; k++) begin
      @(negedge clk);
      if (vsen_n !== 1'b0) bad_en++;
      if (vsck !== k[0]) bad_clk++;
      if (dreq_n !== 1'b1) bad_en++;
      if (k[0]) got = {got[30:0], ~vsda};
    end
    chk("R5 frame low whole line", bad_en, 0);
    chk("R5 vsck half rate", bad_clk, 0);
    chk("R6 pixel order and polarity", got, 32'hA53C0F81);
    @(negedge clk);
    chk("R5 frame ends", vsen_n, 1'b1);
    chk("R8 lb_done serial", lb_done, 1'b1);
    dack_n = 1'b1;
  endtask

  task automatic t_parallel();
    do_reset(2'd2, 1'b1, 16'd20);
    mem[0] = 8'h11; mem[1] = 8'hE2; mem[2] = 8'h7B; mem[3] = 8'hC4;
    @(negedge clk);
    lb_ready = 1'b1;
    @(negedge clk);
    chk("R7 dreq asserted", dreq_n, 1'b0);
    chk("R7 bus off without dack", pd_oe, 1'b0);
    repeat (2) @(negedge clk);
    chk("R7 dreq holds", dreq_n, 1'b0);
    dack_n = 1'b0;
    #1;
    chk("R7 bus on with dack", pd_oe, 1'b1);
    chk("R7 byte0", pd_dat, 8'h11);
    @(negedge clk);
    chk("R7 byte1", pd_dat, 8'hE2);
    @(negedge clk);
    chk("R7 byte2", pd_dat, 8'h7B);
    @(negedge clk);
    chk("R7 byte3", pd_dat, 8'hC4);
    @(negedge clk);
    chk("R8 dreq released", dreq_n, 1'b1);
    chk("R8 lb_done pulse", lb_done, 1'b1);
    chk("R7 bus off after line", pd_oe, 1'b0);
    repeat (5) @(negedge clk);
    chk("R8 dreq stays high with dack low", dreq_n, 1'b1);
    chk("R8 lb_done one cycle", lb_done, 1'b0);
    dack_n = 1'b1;
    mem[0] = 8'h5A;
    lb_ready = 1'b1;
    @(negedge clk);
    chk("R8 dreq reasserts on next line", dreq_n, 1'b0);
    chk("R7 new byte0", pd_dat, 8'h5A);
    dack_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 second line released", dreq_n, 1'b1);
    dack_n = 1'b1;
  endtask

  task automatic t_collide();
    int n;
    do_reset(2'd0, 1'b1, 16'd40);
    mem[0] = 8'h01; mem[1] = 8'h02; mem[2] = 8'h03; mem[3] = 8'h04;
    wait_fall(n);
    chk("R9 first start no overrun", overrun, 1'b0);
    lb_ready = 1'b1;
    repeat (35) @(negedge clk);
    dack_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 delivery ends before start", lb_done, 1'b1);
    dack_n = 1'b1;
    @(negedge clk);
    chk("R9 start at interval", start_n, 1'b0);
    chk("R9 same-cycle delivery no overrun", overrun, 1'b0);
    repeat (40) @(negedge clk);
    chk("R9 next start", start_n, 1'b0);
    chk("R9 undelivered line overrun", overrun, 1'b1);
    @(negedge clk);
    chk("R9 overrun one cycle", overrun, 1'b0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    mem[0] = '0; mem[1] = '0; mem[2] = '0; mem[3] = '0;
    @(negedge clk);
    // R1 during reset
    chk("R1 start_n in reset", start_n, 1'b1);
    chk("R1 dreq_n in reset", dreq_n, 1'b1);
    t_reset();
    t_free();
    t_cycle();
    t_trig();
    t_serial();
    t_parallel();
    t_collide();
    summary();
    $finish;
  end
endmodule